// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches one dedicated interrupt pin and a bank of general-purpose port pins, and raises a single request line toward the CPU. Every pin is brought into the clock domain through a two-flop synchroniser. A falling transition on any source that is allowed to interrupt sets a sticky pending flag for that source. The flag holds until the CPU pulses the acknowledge strobe, which clears all pending flags together.

One shared sensitivity input applies to every source. With it low, sources react only to falling edges. With it high, a source also requests while it is held low, and that request persists after an acknowledge for as long as the pin stays low. The dedicated pin can always interrupt. Each port pin has its own select bit, which is the same bit that switches on that pin's pull-up. A port pin whose select bit is clear is ignored.

The source flag vector shows which sources have a latched falling edge. Bit 0 belongs to the dedicated pin and bit i+1 to port pin i.

Top module: `eid_detector`

## Requirements
- R1: While reset is asserted, and after it is released with all pins high, `irq_req` is 0 and `src_flag` is all zeros.
- R2: With `sense_lvl` = 0, a falling edge on `irq_pin_n` sets `src_flag[0]` and `irq_req`. Both are visible after the third rising clock edge that follows the pin change. In this mode `irq_req` equals the OR of `src_flag`.
- R3: A set flag stays set until `ack` is sampled high on a rising edge. That edge clears every flag.
- R4: With `sense_lvl` = 1, `irq_req` is 1 while any enabled source is held low, including after `ack` has cleared the flags. It returns to 0 once all enabled sources are high and no flags are set.
- R5: An enabled port pin (`port_sel[i]` = 1) uses the same sensitivity as the dedicated pin and latches its falling edge in `src_flag[i+1]`.
- R6: A port pin with `port_sel[i]` = 0 never sets its flag and never drives `irq_req`. Clearing `port_sel[i]` discards a flag already pending for that pin on the next clock edge.
- R7: A falling edge detected in the same cycle as `ack` leaves its flag set. Setting wins over clearing.
- R8: With `sense_lvl` = 0, a pin that stays low after `ack` does not raise the request again until the pin rises and falls once more.
- R9: Whenever any bit of `src_flag` is set, `irq_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_pin_n | input | 1 | Raw dedicated interrupt pin, active low |
| port_pin | input | NPORT | Raw port pins |
| sense_lvl | input | 1 | 0: falling edge only; 1: falling edge or low level |
| port_sel | input | NPORT | Per-pin pull-up and interrupt select |
| ack | input | 1 | Acknowledge strobe, clears pending flags |
| irq_req | output | 1 | Combined interrupt request |
| src_flag | output | NPORT+1 | Latched falling-edge flags; bit 0 is the dedicated pin |

## Verification
The assertions assume that `ack`, `sense_lvl` and `port_sel` are synchronous to `clk`, because only the pins pass through the synchroniser. The stimulus therefore changes every input on the falling clock edge. Pin levels are held for at least three cycles, so each change reaches the edge detector before the next one. The bench allows for the reset synchroniser's two-cycle release before it drives any pin low.

// File: rtl/eid_pkg.sv
package eid_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/eid_rst_sync.sv
module eid_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/eid_pin_sync.sv
module eid_pin_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = raw;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_comb begin
      stg_d[k] = stg_q[k-1];
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[k] <= '1;
      else        stg_q[k] <= stg_d[k];
    end
  end

  assign synced = stg_q[STAGES-1];
endmodule

// File: rtl/eid_src_cell.sv
module eid_src_cell
  import eid_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  logic   enable,
  input  sense_e sense,
  input  logic   ack,
  output logic   pend,
  output logic   lvl_act
);
  logic prev_q, prev_d;
  logic pend_q, pend_d, pend_ce;
  logic fall;

  always_comb begin
    prev_d  = pin_s;
    fall    = enable & prev_q & ~pin_s;
    // a new edge outranks a simultaneous acknowledge
    if (!enable)   pend_d = 1'b0;
    else if (fall) pend_d = 1'b1;
    else if (ack)  pend_d = 1'b0;
    else           pend_d = pend_q;
    pend_ce = (pend_d != pend_q);
    lvl_act = enable & (sense == SENSE_LEVEL) & ~pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (pend_ce) pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/eid_detector.sv
module eid_detector
  import eid_pkg::*;
#(
  parameter int unsigned NPORT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pin,
  input  logic             sense_lvl,
  input  logic [NPORT-1:0] port_sel,
  input  logic             ack,
  output logic             irq_req,
  output logic [NPORT:0]   src_flag
);
  localparam int unsigned NSRC = NPORT + 1;

  logic            rst_n_i;
  logic [NSRC-1:0] raw_all, sync_all, en_all, pend_all, lvl_all;
  sense_e          sense;

  assign raw_all = {port_pin, irq_pin_n};
  assign en_all  = {port_sel, 1'b1};
  assign sense   = sense_e'(sense_lvl);

  eid_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  eid_pin_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .raw(raw_all), .synced(sync_all)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    eid_src_cell u_cell (
      .clk(clk), .rst_n(rst_n_i), .pin_s(sync_all[i]), .enable(en_all[i]),
      .sense(sense), .ack(ack), .pend(pend_all[i]), .lvl_act(lvl_all[i])
    );
  end

  always_comb begin
    irq_req  = (|pend_all) | (|lvl_all);
    src_flag = pend_all;
  end
endmodule

// File: rtl/eid_detector_chk.sv
module eid_detector_chk #(
  parameter int unsigned NPORT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sense_lvl,
  input logic [NPORT-1:0] port_sel,
  input logic             ack,
  input logic             irq_req,
  input logic [NPORT:0]   src_flag
);
  logic [NPORT:0] en_ext;
  assign en_ext = {port_sel, 1'b1};

  AST_FLAG_DRIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_flag) |-> irq_req); // R9

  AST_EDGE_MODE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_lvl |-> (irq_req == (|src_flag))); // R2

  for (genvar i = 0; i <= NPORT; i++) begin : g_bit
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_flag[i]) && !$past(ack) && $past(en_ext[i])) |-> src_flag[i]); // R3
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!port_sel[i]) |-> !src_flag[i+1]); // R6
  end
endmodule

bind eid_detector eid_detector_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sense_lvl(sense_lvl), .port_sel(port_sel),
  .ack(ack), .irq_req(irq_req), .src_flag(src_flag)
);

// File: tb/sim_eid_detector.sv
module sim_eid_detector;
  localparam int NPORT = 8;
  localparam int NVEC  = 6;
  // {lvl, sel[8], irq_pin, port[8], exp_req, exp_flag[9]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 9'h000},
    {1'b0, 8'h00, 1'b0, 8'hFF, 1'b1, 9'h001},
    {1'b0, 8'h0F, 1'b1, 8'h00, 1'b1, 9'h01E},
    {1'b1, 8'hF0, 1'b1, 8'h0F, 1'b1, 9'h1E0},
    {1'b1, 8'h00, 1'b1, 8'h00, 1'b0, 9'h000},
    {1'b0, 8'hFF, 1'b0, 8'h7E, 1'b1, 9'h103}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_pin_n = 1'b1, sense_lvl = 1'b0, ack = 1'b0;
  logic [NPORT-1:0] port_pin = '1, port_sel = '0;
  logic irq_req;
  logic [NPORT:0] src_flag;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  eid_detector #(.NPORT(NPORT)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin(port_pin),
    .sense_lvl(sense_lvl), .port_sel(port_sel), .ack(ack),
    .irq_req(irq_req), .src_flag(src_flag)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic idle();
    irq_pin_n = 1'b1; port_pin = '1; cyc(3); pulse_ack(); cyc(1);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        chk("R1 in reset", {irq_req, src_flag}, 10'h000);
        rst_n = 1'b1; cyc(5);
        chk("R1 after release", {irq_req, src_flag}, 10'h000);

        for (int v = 0; v < NVEC; v++) begin
          idle();
          sense_lvl = VEC[v][27]; port_sel = VEC[v][26:19]; cyc(1);
          irq_pin_n = VEC[v][18]; port_pin = VEC[v][17:10];
          cyc(3);
          chk("R5 vector", {irq_req, src_flag}, VEC[v][9:0]);
          irq_pin_n = 1'b1; port_pin = '1; cyc(3);
          chk("R3 sticky after release", {irq_req, src_flag},
              {|VEC[v][8:0], VEC[v][8:0]});
        end

        // R2: timing of dedicated pin edge, edge mode
        idle(); sense_lvl = 1'b0; port_sel = '0;
        irq_pin_n = 1'b0; cyc(2);
        chk("R2 not yet after two edges", {9'h0, irq_req}, 10'h0);
        cyc(1);
        chk("R2 after third edge", {irq_req, src_flag}, 10'h201);
        // R8: held low, ack, no re-trigger
        pulse_ack(); cyc(3);
        chk("R8 held low edge mode", {irq_req, src_flag}, 10'h000);
        irq_pin_n = 1'b1; cyc(3); irq_pin_n = 1'b0; cyc(3);
        chk("R8 new edge retriggers", {irq_req, src_flag}, 10'h201);

        // R4: level mode held low survives ack
        idle(); sense_lvl = 1'b1; port_sel = 8'h04; cyc(1);
        port_pin = 8'hFB; cyc(3);
        chk("R4 level pending", {irq_req, src_flag}, 10'h208);
        pulse_ack(); cyc(1);
        chk("R4 level after ack", {irq_req, src_flag}, 10'h200);
        port_pin = '1; cyc(3);
        chk("R4 released", {irq_req, src_flag}, 10'h000);

        // R6: clearing select discards pending flag
        idle(); sense_lvl = 1'b0; port_sel = 8'h80; cyc(1);
        port_pin = 8'h7F; cyc(3);
        chk("R6 pending set", {irq_req, src_flag}, 10'h300);
        port_sel = 8'h00; cyc(1);
        chk("R6 deselected", {irq_req, src_flag}, 10'h000);
        sense_lvl = 1'b1; cyc(2);
        chk("R6 deselected low in level mode", {irq_req, src_flag}, 10'h000);

        // R7: ack in the fall-detect cycle
        idle(); sense_lvl = 1'b0; port_sel = '0;
        irq_pin_n = 1'b0; cyc(2);
        ack = 1'b1; cyc(1); ack = 1'b0;
        chk("R7 set beats ack", {irq_req, src_flag}, 10'h201);
        pulse_ack();
        chk("R3 ack clears", {irq_req, src_flag}, 10'h000);
        chk("R9 no flag no req edge", {9'h0, irq_req}, 10'h0);
      end
      begin
        cyc(20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule